// File: doc/BRIEF.md
# BCD time and calendar counter

This block keeps wall-clock time and calendar date as a set of packed BCD counters. A free-running clock carries a 32768 Hz enable pulse. A binary prescaler divides that enable down to a one-second step. The step drives a chain of seconds, minutes and hours in 24-hour form. Each midnight carry then advances the day of week, the date, the month and a two-digit year. The date counter knows the length of each month and adds February 29 in leap years. Every field is visible in parallel at the outputs.

Software or a sequencer sets the time through a parallel load. One load cycle writes every field and restarts the prescaler, so a full second passes before the first step. A stop input freezes the prescaler and the counters, which saves power or holds a stable snapshot. A test output carries a square wave taken from a prescaler stage. With the default sizing this wave runs at 512 Hz.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset, the outputs read seconds 00, minutes 00, hours 00, day of week 1, date 01, month 01 and year 00 (BCD 8'h00/8'h00/8'h00/3'd1/8'h01/8'h01/8'h00), and the square wave output is 0.
- R2: Each field is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. Seconds and minutes count 00 to 59 and wrap to 00. Seconds wrap only on a one-second step, and this wrap advances minutes. Minutes wrap only when seconds also wrap, and this wrap advances hours.
- R3: Hours count 00 to 23. When 23:59:59 steps, the time becomes 00:00:00 and the day of week and the date both advance.
- R4: The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12. It wraps to 01 after 30 in months 04, 06, 09 and 11. Each wrap advances the month.
- R5: In February, the date wraps after 29 when the year value is a multiple of four, 00 included. In any other year it wraps after 28.
- R6: Month counts 01 to 12. When December ends, the month becomes 01 and the year advances; year 99 wraps to 00.
- R7: The day of week counts 1 to 7 in a 3-bit field and wraps from 7 to 1 each time the date advances.
- R8: The prescaler advances only in cycles where the 32768 Hz enable is 1 and stop is 0. A one-second step happens on the 2^PRESCALE_BITS-th such cycle counted from reset or load.
- R9: While stop is 1 and load is 0, every time field, the prescaler and the square wave output hold their values.
- R10: A load pulse writes all seven fields in the next cycle and clears the prescaler, whether or not stop is 1. The next seconds step then needs a further full 2^PRESCALE_BITS enabled cycles.
- R11: The square wave output is bit TAP_BIT of the prescaler. It toggles every 2^TAP_BIT enabled cycles.
- R12: A step that carries through several fields updates all of them in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | 32768 Hz enable pulse, one cycle wide |
| stop_i | input | 1 | Freeze prescaler and counters |
| load_i | input | 1 | Write all load fields this cycle |
| ld_sec_i | input | 8 | Seconds to load, BCD |
| ld_min_i | input | 8 | Minutes to load, BCD |
| ld_hour_i | input | 8 | Hours to load, BCD |
| ld_dow_i | input | 3 | Day of week to load, 1 to 7 |
| ld_date_i | input | 8 | Date to load, BCD |
| ld_mon_i | input | 8 | Month to load, BCD |
| ld_year_i | input | 8 | Year to load, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD |
| dow_o | output | 3 | Day of week |
| date_o | output | 8 | Date, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| sq_o | output | 1 | Frequency test square wave |

## Verification
The range and month-length properties assume that every load carries a legal calendar value. That means valid BCD digits, fields in range, and a date that exists in the loaded month and year. A load of 31 in April, for example, is never issued. The bench loads only such values, chosen to sit just before each rollover: end of minute, end of day, end of a 30-day and a 31-day month, February in leap and common years, and end of year 99. The enable input is driven with gaps so that the prescaler counts enables, not clock cycles.

// File: rtl/tk_pkg.sv
package tk_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
    } tk_time_t;

    typedef struct packed {
        logic [2:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
    } tk_date_t;

    // Advance a packed BCD value, wrapping from last to first.
    function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v == last)
            return first;
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A two-digit BCD year is a multiple of four when (2*tens + units) mod 4 is 0.
    function automatic logic year_is_leap(input logic [7:0] y);
        logic [1:0] r;
        r = {y[4], 1'b0} + y[1:0];
        return (r == 2'd0);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon,
                                              input logic [7:0] year);
        case (mon)
            8'h02:                      return year_is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
    parameter int CNT_W   = 15,
    parameter int TAP_BIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic stop_i,
    input  logic clear_i,
    output logic step_o,
    output logic tap_o
);
    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             adv;

    always_comb begin
        adv    = en_i && !stop_i && !clear_i;
        step_o = adv && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (adv)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign tap_o = cnt_q[TAP_BIT];

endmodule

// File: rtl/tk_time_chain.sv
module tk_time_chain
    import tk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step_i,
    input  logic     load_i,
    input  tk_time_t load_val_i,
    output tk_time_t cur_o,
    output logic     day_o
);
    tk_time_t t_d, t_q;
    logic     sec_wrap, min_wrap;

    always_comb begin
        sec_wrap = step_i && (t_q.sec == 8'h59);
        min_wrap = sec_wrap && (t_q.min == 8'h59);
        day_o    = min_wrap && (t_q.hour == 8'h23) && !load_i;
        t_d      = t_q;
        if (load_i) begin
            t_d = load_val_i;
        end else if (step_i) begin
            t_d.sec = bcd_next(t_q.sec, 8'h59, 8'h00);
            if (sec_wrap)
                t_d.min = bcd_next(t_q.min, 8'h59, 8'h00);
            if (min_wrap)
                t_d.hour = bcd_next(t_q.hour, 8'h23, 8'h00);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            t_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00};
        else
            t_q <= t_d;
    end

    assign cur_o = t_q;

endmodule

// File: rtl/tk_date_chain.sv
module tk_date_chain
    import tk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step_i,
    input  logic     load_i,
    input  tk_date_t load_val_i,
    output tk_date_t cur_o
);
    tk_date_t d_d, d_q;
    logic     last_day;

    always_comb begin
        last_day = (d_q.date == month_last(d_q.mon, d_q.year));
        d_d      = d_q;
        if (load_i) begin
            d_d = load_val_i;
        end else if (step_i) begin
            d_d.dow = (d_q.dow == 3'd7) ? 3'd1 : d_q.dow + 3'd1;
            if (!last_day) begin
                d_d.date = bcd_next(d_q.date, 8'h31, 8'h01);
            end else begin
                d_d.date = 8'h01;
                d_d.mon  = bcd_next(d_q.mon, 8'h12, 8'h01);
                if (d_q.mon == 8'h12)
                    d_d.year = bcd_next(d_q.year, 8'h99, 8'h00);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            d_q <= '{dow: 3'd1, date: 8'h01, mon: 8'h01, year: 8'h00};
        else
            d_q <= d_d;
    end

    assign cur_o = d_q;

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
    import tk_pkg::*;
#(
    parameter int PRESCALE_BITS = 15,
    parameter int TAP_BIT       = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en_i,
    input  logic       stop_i,
    input  logic       load_i,
    input  logic [7:0] ld_sec_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hour_i,
    input  logic [2:0] ld_dow_i,
    input  logic [7:0] ld_date_i,
    input  logic [7:0] ld_mon_i,
    input  logic [7:0] ld_year_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [2:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       sq_o
);
    logic     sec_step;
    logic     day_step;
    tk_time_t time_ld, time_cur;
    tk_date_t date_ld, date_cur;

    assign time_ld = '{sec: ld_sec_i, min: ld_min_i, hour: ld_hour_i};
    assign date_ld = '{dow: ld_dow_i, date: ld_date_i, mon: ld_mon_i, year: ld_year_i};

    tk_prescaler #(
        .CNT_W   (PRESCALE_BITS),
        .TAP_BIT (TAP_BIT)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (tick_en_i),
        .stop_i  (stop_i),
        .clear_i (load_i),
        .step_o  (sec_step),
        .tap_o   (sq_o)
    );

    tk_time_chain u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (sec_step),
        .load_i     (load_i),
        .load_val_i (time_ld),
        .cur_o      (time_cur),
        .day_o      (day_step)
    );

    tk_date_chain u_date (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (day_step),
        .load_i     (load_i),
        .load_val_i (date_ld),
        .cur_o      (date_cur)
    );

    assign sec_o  = time_cur.sec;
    assign min_o  = time_cur.min;
    assign hour_o = time_cur.hour;
    assign dow_o  = date_cur.dow;
    assign date_o = date_cur.date;
    assign mon_o  = date_cur.mon;
    assign year_o = date_cur.year;

endmodule

// File: rtl/tk_checker.sv
module tk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en_i,
    input logic       stop_i,
    input logic       load_i,
    input logic [7:0] ld_sec_i,
    input logic [7:0] ld_min_i,
    input logic [7:0] ld_hour_i,
    input logic [2:0] ld_dow_i,
    input logic [7:0] ld_date_i,
    input logic [7:0] ld_mon_i,
    input logic [7:0] ld_year_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [2:0] dow_o,
    input logic [7:0] date_o,
    input logic [7:0] mon_o,
    input logic [7:0] year_o,
    input logic       sq_o,
    input logic       sec_step,
    input logic       day_step
);

    p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o <= 8'h59 && sec_o[3:0] <= 4'd9 && min_o <= 8'h59 && min_o[3:0] <= 4'd9);

    p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hour_o <= 8'h23 && hour_o[3:0] <= 4'd9);

    p_short_month_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_o == 8'h04 || mon_o == 8'h06 || mon_o == 8'h09 || mon_o == 8'h11)
        |-> (date_o >= 8'h01 && date_o <= 8'h30));

    p_feb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_o == 8'h02) |-> (date_o >= 8'h01 && date_o <= 8'h29));

    p_month_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mon_o >= 8'h01 && mon_o <= 8'h12 && year_o[3:0] <= 4'd9 && year_o[7:4] <= 4'd9);

    p_dow_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dow_o >= 3'd1 && dow_o <= 3'd7);

    p_sec_only_on_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !sec_step) |=> $stable(sec_o));

    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !load_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                                 $stable(dow_o) && $stable(date_o) && $stable(mon_o) &&
                                 $stable(year_o) && $stable(sq_o)));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sec_o == $past(ld_sec_i) && min_o == $past(ld_min_i) &&
                    hour_o == $past(ld_hour_i) && dow_o == $past(ld_dow_i) &&
                    date_o == $past(ld_date_i) && mon_o == $past(ld_mon_i) &&
                    year_o == $past(ld_year_i) && !sq_o));

    p_sq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en_i && !load_i) |=> $stable(sq_o));

    p_midnight_r12: assert property (@(posedge clk) disable iff (!rst_n)
        day_step |=> (sec_o == 8'h00 && min_o == 8'h00 && hour_o == 8'h00 &&
                      dow_o != $past(dow_o) && date_o != $past(date_o)));

endmodule

bind bcd_timekeeper tk_checker u_tk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en_i (tick_en_i),
    .stop_i    (stop_i),
    .load_i    (load_i),
    .ld_sec_i  (ld_sec_i),
    .ld_min_i  (ld_min_i),
    .ld_hour_i (ld_hour_i),
    .ld_dow_i  (ld_dow_i),
    .ld_date_i (ld_date_i),
    .ld_mon_i  (ld_mon_i),
    .ld_year_i (ld_year_i),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour_o),
    .dow_o     (dow_o),
    .date_o    (date_o),
    .mon_o     (mon_o),
    .year_o    (year_o),
    .sq_o      (sq_o),
    .sec_step  (sec_step),
    .day_step  (day_step)
);

// File: tb/bcd_timekeeper_tb_top.sv
module bcd_timekeeper_tb_top;
    localparam int PB  = 4;
    localparam int TAP = 1;
    localparam int SEC_EN = 1 << PB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0;
    logic [2:0] ld_dow_i = 3'd1;
    logic [7:0] ld_date_i = 8'h01, ld_mon_i = 8'h01, ld_year_i = '0;
    logic [7:0] sec_o, min_o, hour_o, date_o, mon_o, year_o;
    logic [2:0] dow_o;
    logic       sq_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit compare_on = 1'b0;

    // reference state, plain binary integers
    int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year, m_pre;

    always #5 clk = ~clk;

    bcd_timekeeper #(.PRESCALE_BITS(PB), .TAP_BIT(TAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .stop_i(stop_i), .load_i(load_i),
        .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i), .ld_dow_i(ld_dow_i),
        .ld_date_i(ld_date_i), .ld_mon_i(ld_mon_i), .ld_year_i(ld_year_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .mon_o(mon_o), .year_o(year_o), .sq_o(sq_o)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int mon, input int year);
        if (mon == 2) return (year % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at time %0t", tag, act, exp, $time);
        end
    endtask

    // reference model update at every active edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1;
            m_date = 1; m_mon = 1; m_year = 0; m_pre = 0;
        end else if (load_i) begin
            m_sec = from_bcd(ld_sec_i); m_min = from_bcd(ld_min_i);
            m_hour = from_bcd(ld_hour_i); m_dow = int'(ld_dow_i);
            m_date = from_bcd(ld_date_i); m_mon = from_bcd(ld_mon_i);
            m_year = from_bcd(ld_year_i); m_pre = 0;
        end else if (tick_en_i && !stop_i) begin
            m_pre = m_pre + 1;
            if (m_pre == SEC_EN) begin
                m_pre = 0;
                m_sec = m_sec + 1;
                if (m_sec == 60) begin
                    m_sec = 0; m_min = m_min + 1;
                    if (m_min == 60) begin
                        m_min = 0; m_hour = m_hour + 1;
                        if (m_hour == 24) begin
                            m_hour = 0;
                            m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                            m_date = m_date + 1;
                            if (m_date > days_in(m_mon, m_year)) begin
                                m_date = 1; m_mon = m_mon + 1;
                                if (m_mon == 13) begin
                                    m_mon = 1;
                                    m_year = (m_year + 1) % 100;
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check(sec_o == to_bcd(m_sec),   "R2 seconds", sec_o, to_bcd(m_sec));
            check(min_o == to_bcd(m_min),   "R2 minutes", min_o, to_bcd(m_min));
            check(hour_o == to_bcd(m_hour), "R3 hours", hour_o, to_bcd(m_hour));
            check(dow_o == 3'(m_dow),       "R7 day of week", dow_o, m_dow);
            check(date_o == to_bcd(m_date), "R4 date", date_o, to_bcd(m_date));
            check(mon_o == to_bcd(m_mon),   "R6 month", mon_o, to_bcd(m_mon));
            check(year_o == to_bcd(m_year), "R6 year", year_o, to_bcd(m_year));
            check(sq_o == 1'((m_pre >> TAP) & 1), "R11 square wave", sq_o, (m_pre >> TAP) & 1);
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    task automatic load(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                        input logic [2:0] dw, input logic [7:0] d, input logic [7:0] mo,
                        input logic [7:0] y);
        ld_hour_i = h; ld_min_i = mi; ld_sec_i = s; ld_dow_i = dw;
        ld_date_i = d; ld_mon_i = mo; ld_year_i = y;
        load_i = 1'b1; tick_en_i = 1'b0;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // n enabled cycles, with an idle cycle after every third one
    task automatic run_en(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en_i = 1'b1;
            @(negedge clk);
            if (i % 3 == 2) begin
                tick_en_i = 1'b0;
                @(negedge clk);
            end
        end
        tick_en_i = 1'b0;
    endtask

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1: reset values, observed while reset is still asserted
        check(sec_o == 8'h00 && min_o == 8'h00 && hour_o == 8'h00, "R1 reset time", {hour_o, min_o, sec_o}, 0);
        check(dow_o == 3'd1 && date_o == 8'h01 && mon_o == 8'h01 && year_o == 8'h00 && !sq_o,
              "R1 reset date", {dow_o, date_o, mon_o, year_o}, 24'h010100);
        rst_n = 1'b1;
        compare_on = 1'b1;

        // R8: one enable short of a second leaves seconds at 00, the next one steps
        run_en(SEC_EN - 1);
        check(sec_o == 8'h00, "R8 before step", sec_o, 8'h00);
        run_en(1);
        check(sec_o == 8'h01, "R8 step", sec_o, 8'h01);
        run_en(SEC_EN * 70);
        check(min_o == 8'h01 && sec_o == 8'h11, "R2 minute carry", {min_o, sec_o}, 16'h0111);

        // R3, R12: end of day, dow 7 wraps to 1 (R7), date in a 31-day month
        load(8'h23, 8'h59, 8'h58, 3'd7, 8'h15, 8'h03, 8'h24);
        run_en(SEC_EN * 2);
        check(hour_o == 8'h00 && min_o == 8'h00 && sec_o == 8'h00, "R12 midnight", {hour_o, min_o, sec_o}, 0);
        check(dow_o == 3'd1 && date_o == 8'h16, "R7 dow wrap", {dow_o, date_o}, {3'd1, 8'h16});

        // R4: 30-day month
        load(8'h23, 8'h59, 8'h59, 3'd2, 8'h30, 8'h04, 8'h23);
        run_en(SEC_EN);
        check(date_o == 8'h01 && mon_o == 8'h05, "R4 April end", {mon_o, date_o}, 16'h0501);
        load(8'h23, 8'h59, 8'h59, 3'd2, 8'h30, 8'h01, 8'h23);
        run_en(SEC_EN);
        check(date_o == 8'h31 && mon_o == 8'h01, "R4 January 31", {mon_o, date_o}, 16'h0131);

        // R5: leap years 00 and 96, common years 01 and 10
        load(8'h23, 8'h59, 8'h59, 3'd3, 8'h28, 8'h02, 8'h00);
        run_en(SEC_EN);
        check(date_o == 8'h29 && mon_o == 8'h02, "R5 year 00 leap", {mon_o, date_o}, 16'h0229);
        run_en(SEC_EN * 3600 * 0 + SEC_EN);
        load(8'h23, 8'h59, 8'h59, 3'd4, 8'h29, 8'h02, 8'h96);
        run_en(SEC_EN);
        check(date_o == 8'h01 && mon_o == 8'h03, "R5 Feb 29 end", {mon_o, date_o}, 16'h0301);
        load(8'h23, 8'h59, 8'h59, 3'd5, 8'h28, 8'h02, 8'h01);
        run_en(SEC_EN);
        check(date_o == 8'h01 && mon_o == 8'h03, "R5 year 01 common", {mon_o, date_o}, 16'h0301);
        load(8'h23, 8'h59, 8'h59, 3'd5, 8'h28, 8'h02, 8'h10);
        run_en(SEC_EN);
        check(date_o == 8'h01 && mon_o == 8'h03, "R5 year 10 common", {mon_o, date_o}, 16'h0301);

        // R6: end of year 99
        load(8'h23, 8'h59, 8'h59, 3'd6, 8'h31, 8'h12, 8'h99);
        run_en(SEC_EN);
        check(year_o == 8'h00 && mon_o == 8'h01 && date_o == 8'h01, "R6 year wrap",
              {year_o, mon_o, date_o}, 24'h000101);

        // R9: stop freezes everything while enables keep arriving
        run_en(SEC_EN + 3);
        held = sec_o;
        stop_i = 1'b1;
        run_en(SEC_EN * 3);
        check(sec_o == held, "R9 stop hold", sec_o, held);

        // R10: load while stopped, then a full second after release
        load(8'h12, 8'h34, 8'h56, 3'd4, 8'h07, 8'h08, 8'h42);
        check(sec_o == 8'h56 && hour_o == 8'h12 && year_o == 8'h42 && !sq_o, "R10 load stopped",
              {hour_o, sec_o, year_o}, 24'h125642);
        stop_i = 1'b0;
        run_en(SEC_EN - 1);
        check(sec_o == 8'h56, "R10 full second", sec_o, 8'h56);
        run_en(1);
        check(sec_o == 8'h57, "R10 first step", sec_o, 8'h57);

        // R11: square wave rises after 2^TAP enables
        load(8'h00, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h00);
        run_en(1 << TAP);
        check(sq_o == 1'b1, "R11 tap rise", sq_o, 1);
        run_en(1 << TAP);
        check(sq_o == 1'b0, "R11 tap fall", sq_o, 0);

        run_en(20);
        summary();
    end

endmodule